// File: doc/BRIEF.md
# Pipelined Fifth-Order Chebyshev Evaluator

This block computes T5(x) = 16x^5 − 20x^3 + 5x on a stream of signed fixed-point samples and accepts one sample on every clock. The polynomial is rewritten as x·((4x²)·(4x² − 5) + 5). With this form the datapath needs only two-input adds, subtracts and multiplies. The factors of four are left shifts, so they need no multiplier.

The work is split into three multiply/add sections, each built like a hard arithmetic slice:

- **Squaring section:** forms x².
- **Middle section:** holds a pre-subtract, a multiply and a post-add.
- **Final section:** multiplies by x.

Each section has its own input, internal and output registers. Between sections the wide product is cut back to a Q.14 operand. The integer bits are kept and the low fraction bits are dropped, which is an arithmetic shift and therefore floors. A delay line carries x past the first two sections so that it meets its partner operand in the final section. A valid strobe travels alongside the data.

Top module: `cheb5_eval`

## Requirements
- R1: A sample taken with valid_in high at rising edge k shows up with valid_out high after rising edge k+10. The latency is fixed at LAT = 11 register stages.
- R2: x_in is Q2.14 and y_out is Q6.14, both two's complement. When valid_out is high, y_out equals the value computed as follows, where >> is a flooring arithmetic shift:
  - s = (x·x) >> 14
  - q = 4s
  - v = ((q − 5·2^14)·q + 5·2^28) >> 14
  - y = (v·x) >> 14
- R3: The endpoints are exact: x = 16384 (+1.0) gives 16384, x = −16384 gives −16384, and x = 0 gives 0.
- R4: Truncation floors toward minus infinity, so results are not symmetric in sign. x = 200 gives 999 and x = −200 gives −1000.
- R5: Samples on consecutive clocks produce results on consecutive clocks, each matching its own input.
- R6: A clock with valid_in low yields a clock with valid_out low at the matching output slot. The samples on either side of such a gap still get correct results, so the delayed copy of x stays aligned.
- R7: The reset is synchronous and active high. While rst is high, and on the clock after it falls, valid_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Marks x_in as a sample |
| x_in | input | 16 | Sample, signed Q2.14 |
| valid_out | output | 1 | Marks y_out as a result |
| y_out | output | 20 | T5(x), signed Q6.14 |

## Verification
Every result is due ten rising edges after the edge that takes in its sample. That edge is the eleventh register counted from the input. The bench logs valid_in and x_in at each rising edge. At each falling edge it compares valid_out and y_out with the entry logged ten edges earlier, passed through a behavioural evaluation of the floored formula. Directed endpoint and sign-asymmetry samples are sent back to back, a gap follows them, and random samples arrive with random bubbles. As a result, alignment, throughput and the truncation rule are all checked in the same slot-exact way.

// File: rtl/cheb5_eval.sv
module cheb5_eval #(
  parameter int XW   = 16,
  parameter int FRAC = 14,
  parameter int MW   = 20,
  parameter int OW   = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  logic signed [XW-1:0] x_in,
  output logic                 valid_out,
  output logic signed [OW-1:0] y_out
);
  localparam int LAT_A = 3;
  localparam int LAT_B = 5;
  localparam int LAT_C = 3;
  localparam int LAT   = LAT_A + LAT_B + LAT_C;
  localparam int XDLY  = LAT_A + LAT_B - 1;
  localparam int PW1   = 2 * XW;
  localparam int PW2   = 2 * MW;
  localparam int PW3   = MW + XW;
  localparam logic signed [MW-1:0]  FIVE_Q = MW'(5) <<< FRAC;
  localparam logic signed [PW2-1:0] FIVE_P = PW2'(5) <<< (2 * FRAC);

  // squaring section
  logic signed [XW-1:0]  a_x;
  logic signed [PW1-1:0] a_p;
  logic signed [MW-1:0]  a_o;

  always_ff @(posedge clk) begin
    a_x <= x_in;
    a_p <= a_x * a_x;
    a_o <= MW'(a_p >>> FRAC);
  end

  // middle section: pre-subtract, multiply, post-add
  logic signed [MW-1:0]  b_s, b_q, b_pa, b_o;
  logic signed [PW2-1:0] b_pr, b_al;

  always_ff @(posedge clk) begin
    b_s  <= a_o;
    b_q  <= b_s <<< 2;
    b_pa <= (b_s <<< 2) - FIVE_Q;
    b_pr <= b_pa * b_q;
    b_al <= b_pr + FIVE_P;
    b_o  <= MW'(b_al >>> FRAC);
  end

  // bypass copy of x
  logic signed [XW-1:0] xd [XDLY];

  always_ff @(posedge clk) begin
    xd[0] <= a_x;
    for (int i = 1; i < XDLY; i++) xd[i] <= xd[i-1];
  end

  // final section
  logic signed [MW-1:0]  c_w;
  logic signed [XW-1:0]  c_x;
  logic signed [PW3-1:0] c_pr;
  logic signed [OW-1:0]  c_o;

  always_ff @(posedge clk) begin
    c_w  <= b_o;
    c_x  <= xd[XDLY-1];
    c_pr <= c_w * c_x;
    c_o  <= OW'(c_pr >>> FRAC);
  end

  // valid tracking
  logic [LAT-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[LAT-2:0], valid_in};
  end

  assign valid_out = vld[LAT-1];
  assign y_out     = c_o;

  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    valid_out == $past(valid_in, LAT));

  a_r7_reset_quiet: assert property (@(posedge clk)
    rst |=> !valid_out);

  a_r2_square_sign: assert property (@(posedge clk) disable iff (rst)
    $past(valid_in, LAT_A) |-> !a_o[MW-1]);

  a_r6_x_align: assert property (@(posedge clk) disable iff (rst)
    $past(valid_in, LAT_A + LAT_B + 1) |-> c_x == $past(x_in, LAT_A + LAT_B + 1));
endmodule

// File: tb/cheb5_eval_test.sv
module cheb5_eval_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_in = 1'b0;
  logic signed [15:0] x_in = '0;
  logic valid_out;
  logic signed [19:0] y_out;

  cheb5_eval uut (
    .clk(clk), .rst(rst), .valid_in(valid_in), .x_in(x_in),
    .valid_out(valid_out), .y_out(y_out)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int n = 0;
  bit done = 0;
  bit hv [4096];
  bit hr [4096];
  longint hx [4096];

  function automatic longint model(longint x);
    longint s, q, v;
    s = (x * x) >>> 14;
    q = 4 * s;
    v = ((q - 5 * 16384) * q + 64'sd1342177280) >>> 14;
    return (v * x) >>> 14;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    n++;
    hv[n % 4096] = valid_in;
    hx[n % 4096] = x_in;
    hr[n % 4096] = rst;
  end

  always @(negedge clk) begin
    if (n > 0) begin
      if (hr[n % 4096]) begin
        check(valid_out == 1'b0, "R7", valid_out, 0);
      end else if (n > 10 && !hr[(n - 10) % 4096]) begin
        bit ev;
        longint ex, ey;
        ev = hv[(n - 10) % 4096];
        ex = hx[(n - 10) % 4096];
        check(valid_out == ev, ev ? "R1" : "R6", valid_out, ev);
        if (ev && valid_out) begin
          ey = model(ex);
          check(longint'(y_out) == ey,
                hv[(n - 11) % 4096] ? "R5 R2" : "R2", y_out, ey);
          if (ex == 16384)  check(y_out == 16384,  "R3", y_out, 16384);
          if (ex == -16384) check(y_out == -16384, "R3", y_out, -16384);
          if (ex == 0)      check(y_out == 0,      "R3", y_out, 0);
          if (ex == 200)    check(y_out == 999,    "R4", y_out, 999);
          if (ex == -200)   check(y_out == -1000,  "R4", y_out, -1000);
        end
      end
    end
  end

  task automatic put(bit v, int x);
    @(negedge clk);
    valid_in = v;
    x_in = 16'(x);
  endtask

  initial begin
    int directed [7] = '{-16384, 0, 16384, 8192, -8192, 200, -200};
    repeat (15) @(negedge clk);
    rst = 1'b0;
    foreach (directed[i]) put(1'b1, directed[i]);
    repeat (3) put(1'b0, 12345);
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(32768, 0)) - 16384;
      put($urandom_range(3, 0) != 0, r);
    end
    repeat (15) put(1'b0, 0);
    finish_run();
  end

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule